// File: doc/BRIEF.md
# Triggered Acquisition Capture Controller

This block steers a stream of 8-bit offset-binary samples from a flash converter into a 2048-word by 8-bit capture memory. The memory sits outside the block. A start command begins a capture. Until a trigger is accepted, samples are written to the memory in a circle. A trigger is a crossing of a programmed level in the chosen direction. It is accepted only after a programmed number of samples in which the crossing condition was false. After the trigger, a programmed number of further samples is written and writing then stops. The block raises a done flag and presents the memory address that holds the trigger sample.

The post-trigger count sets how the finished buffer is split. A small count leaves mostly history from before the event. A count near the depth leaves mostly samples from after it. A force command makes the next accepted sample the trigger, so a capture can finish without a qualifying signal. Parameter registers and the host readout path are outside the block.

Top module: `acq_capture_ctrl`

## Requirements
- R1: After reset, `mem_we`, `mem_addr`, `mem_wdata`, `done` and `trig_addr` are all zero and no writes occur until a start command.
- R2: During a capture, each clock with `smp_vld` high produces one write strobe in the following cycle with `mem_wdata` equal to the sample. Addresses start at 0 after a start command, rise by one per write and wrap from 2047 to 0.
- R3: With `trig_fall` = 0 (rising), the crossing condition is true when the previous accepted sample is below `trig_level` and the current one is at or above it. The comparison is unsigned on the offset-binary codes.
- R4: With `trig_fall` = 1 (falling), the crossing condition is true when the previous accepted sample is above `trig_level` and the current one is at or below it.
- R5: A crossing triggers only if the accepted samples since the start command, or since the last true condition, number at least `holdoff_len`. A true condition seen before that resets the count and does not trigger. `holdoff_len` = 0 arms at once.
- R6: After the trigger sample, exactly `post_len` more samples are written and then writes stop. With `post_len` = 0, the trigger sample is the last write.
- R7: `done` rises one clock after the last write strobe. From then on `trig_addr` holds the address of the trigger sample and stays stable while `done` is high.
- R8: `cmd_force` before the trigger makes the next accepted sample the trigger, whatever the crossing condition and holdoff. That sample may be in the same cycle as the force pulse or later.
- R9: `cmd_start` in any state clears `done` on the next clock and restarts the capture at address 0 with the holdoff count cleared. The first sample can be taken two clocks after the start pulse. A force in the same cycle as a start has no effect.
- R10: While idle or done, `cmd_force` and incoming samples cause no writes and leave `done` and `trig_addr` unchanged.
- R11: Clocks with `smp_vld` low write nothing, do not advance the address and do not count toward holdoff. The first sample after a start has no predecessor and cannot meet the crossing condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 8 | Offset-binary sample from the converter |
| smp_vld | input | 1 | Sample present this clock |
| trig_level | input | 8 | Trigger threshold |
| trig_fall | input | 1 | 0 = rising crossing, 1 = falling crossing |
| holdoff_len | input | 16 | Number of false-condition samples needed before arming |
| post_len | input | 12 | Number of samples written after the trigger sample |
| cmd_start | input | 1 | Begin (or restart) a capture |
| cmd_force | input | 1 | Make the next accepted sample the trigger |
| mem_we | output | 1 | Capture memory write strobe |
| mem_addr | output | 11 | Capture memory write address |
| mem_wdata | output | 8 | Capture memory write data |
| done | output | 1 | Capture finished |
| trig_addr | output | 11 | Address of the trigger sample |

## Verification
The sharpest coincidence is a crossing on the very sample that would have completed the holdoff window. It is provoked by placing a crossing after exactly `holdoff_len`-1 quiet samples, which must block the trigger and restart the count, and then a crossing after a full window, which must fire. A second coincidence is a force pulse on the same sample as a qualifying crossing, and a force pulse in the same cycle as a start. The first must give a single trigger at that sample. The second must be ignored. A behavioural model in the bench predicts the write stream, `done` and `trig_addr` for every clock and is compared against the outputs each cycle.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_HOLD,
    ST_ARMED,
    ST_POST,
    ST_STOP,
    ST_DONE
  } acq_state_t;

endpackage

// File: rtl/acq_edge_detect.sv
module acq_edge_detect #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          take,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] level,
  input  logic          fall,
  output logic          hit
);

  logic [DW-1:0] prev_q;
  logic          have_prev_q;
  logic          up_cross;
  logic          dn_cross;

  // previous accepted sample, forgotten at every restart
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (take) begin
      prev_q      <= smp;
      have_prev_q <= 1'b1;
    end
  end

  always_comb begin
    up_cross = (prev_q < level) && (smp >= level);
    dn_cross = (prev_q > level) && (smp <= level);
    hit      = have_prev_q && (fall ? dn_cross : up_cross);
  end

endmodule

// File: rtl/acq_holdoff.sv
module acq_holdoff #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          hit,
  input  logic [HW-1:0] limit,
  output logic          expire,
  output logic          qualified
);

  logic [HW-1:0] quiet_q;
  logic [HW:0]   quiet_inc;

  always_comb begin
    quiet_inc = {1'b0, quiet_q} + 1'b1;
    expire    = step && !hit && (quiet_inc >= {1'b0, limit});
    qualified = (quiet_q >= limit);
  end

  // consecutive samples with the crossing condition false
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      quiet_q <= '0;
    end else if (step) begin
      if (hit)
        quiet_q <= '0;
      else if (quiet_q != {HW{1'b1}})
        quiet_q <= quiet_inc[HW-1:0];
    end
  end

endmodule

// File: rtl/acq_wr_addr.sv
module acq_wr_addr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          trig,
  input  logic [AW:0]   stop_cnt,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] tptr,
  output logic          last
);

  logic [AW:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr     <= '0;
      tptr     <= '0;
      remain_q <= '0;
    end else if (step) begin
      wptr <= wptr + 1'b1;
      if (trig) begin
        tptr     <= wptr;
        remain_q <= stop_cnt;
      end else if (remain_q != '0) begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  assign last = (remain_q == {{AW{1'b0}}, 1'b1});

endmodule

// File: rtl/acq_capture_ctrl.sv
module acq_capture_ctrl #(
  parameter int DW = 8,
  parameter int AW = 11,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_vld,
  input  logic [DW-1:0] trig_level,
  input  logic          trig_fall,
  input  logic [HW-1:0] holdoff_len,
  input  logic [AW:0]   post_len,
  input  logic          cmd_start,
  input  logic          cmd_force,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic [AW-1:0] trig_addr
);

  import acq_pkg::*;

  acq_state_t    st_q, st_n;
  logic          pre_phase, cap_phase, clr, acc, step_pre, fire;
  logic          hit, expire, hold_ok, last, force_pend_q;
  logic [AW-1:0] wptr, tptr;

  always_comb begin
    pre_phase = (st_q == ST_HOLD) || (st_q == ST_ARMED);
    cap_phase = pre_phase || (st_q == ST_POST);
    clr       = (st_q == ST_CLEAR);
    acc       = smp_vld && cap_phase && !cmd_start;
    step_pre  = acc && pre_phase;
    fire      = step_pre && (cmd_force || force_pend_q || ((st_q == ST_ARMED) && hit));
  end

  acq_edge_detect #(.DW(DW)) u_edge (
    .clk(clk), .rst(rst), .clr(clr), .take(acc), .smp(smp_data),
    .level(trig_level), .fall(trig_fall), .hit(hit)
  );

  acq_holdoff #(.HW(HW)) u_hold (
    .clk(clk), .rst(rst), .clr(clr), .step(step_pre), .hit(hit),
    .limit(holdoff_len), .expire(expire), .qualified(hold_ok)
  );

  acq_wr_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .clr(clr), .step(acc), .trig(fire),
    .stop_cnt(post_len), .wptr(wptr), .tptr(tptr), .last(last)
  );

  // sequencer
  always_comb begin
    st_n = st_q;
    if (cmd_start) begin
      st_n = ST_CLEAR;
    end else begin
      case (st_q)
        ST_CLEAR: st_n = (holdoff_len == '0) ? ST_ARMED : ST_HOLD;
        ST_HOLD: begin
          if (fire)        st_n = (post_len == '0) ? ST_STOP : ST_POST;
          else if (expire) st_n = ST_ARMED;
        end
        ST_ARMED: begin
          if (fire)        st_n = (post_len == '0) ? ST_STOP : ST_POST;
        end
        ST_POST:  if (acc && last) st_n = ST_STOP;
        ST_STOP:  st_n = ST_DONE;
        default:  st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_n;
  end

  // a force seen while no sample arrives waits for the next one
  always_ff @(posedge clk) begin
    if (rst) begin
      force_pend_q <= 1'b0;
    end else if (clr) begin
      force_pend_q <= cmd_force;
    end else if (pre_phase) begin
      if (acc)            force_pend_q <= 1'b0;
      else if (cmd_force) force_pend_q <= 1'b1;
    end else begin
      force_pend_q <= 1'b0;
    end
  end

  // registered memory port and status
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      trig_addr <= '0;
    end else begin
      mem_we <= acc;
      if (acc) begin
        mem_addr  <= wptr;
        mem_wdata <= smp_data;
      end
      if (cmd_start) begin
        done <= 1'b0;
      end else if (st_q == ST_STOP) begin
        done      <= 1'b1;
        trig_addr <= tptr;
      end
    end
  end

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);

  // R7
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(trig_addr));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !done);

  // R5
  armed_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ARMED) |-> hold_ok);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (((st_q == ST_DONE) || (st_q == ST_IDLE)) && !cmd_start) |=> !mem_we);

endmodule

// File: tb/tb_acq_capture_ctrl.sv
module tb_acq_capture_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  smp = '0;
  logic        vld = 1'b0;
  logic [7:0]  cfg_lvl = 8'd128;
  logic        cfg_fall = 1'b0;
  logic [15:0] cfg_hold = '0;
  logic [11:0] cfg_post = '0;
  logic        start = 1'b0;
  logic        frc = 1'b0;
  logic        mem_we, done;
  logic [10:0] mem_addr, trig_addr;
  logic [7:0]  mem_wdata;

  always #4 clk = ~clk;

  acq_capture_ctrl dut (
    .clk(clk), .rst(rst), .smp_data(smp), .smp_vld(vld),
    .trig_level(cfg_lvl), .trig_fall(cfg_fall), .holdoff_len(cfg_hold),
    .post_len(cfg_post), .cmd_start(start), .cmd_force(frc),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .trig_addr(trig_addr)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference model
  int mmode, ptr, quiet, remain, tptr, prevs;
  bit havep, fpend, c, fire;
  int e_we, e_addr, e_data, e_done, e_taddr;

  function automatic bit crossed(int p, int cur, int lv, bit f);
    if (f) return (p > lv) && (cur <= lv);
    return (p < lv) && (cur >= lv);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mmode = 0; ptr = 0; quiet = 0; remain = 0; tptr = 0; prevs = 0;
      havep = 0; fpend = 0;
      e_we = 0; e_addr = 0; e_data = 0; e_done = 0; e_taddr = 0;
    end else begin
      e_we = 0;
      if (start) begin
        mmode = 1; e_done = 0;
      end else begin
        case (mmode)
          1: begin
            ptr = 0; quiet = 0; havep = 0; remain = 0; fpend = frc; mmode = 2;
          end
          2: begin
            if (vld) begin
              e_we = 1; e_addr = ptr; e_data = smp;
              c = havep && crossed(prevs, smp, cfg_lvl, cfg_fall);
              fire = frc || fpend || (c && quiet >= cfg_hold);
              if (fire) begin
                tptr = ptr; remain = cfg_post; fpend = 0;
                mmode = (cfg_post == 0) ? 4 : 3;
              end else begin
                quiet = c ? 0 : quiet + 1;
              end
              prevs = smp; havep = 1; ptr = (ptr + 1) % 2048;
            end else if (frc) begin
              fpend = 1;
            end
          end
          3: begin
            if (vld) begin
              e_we = 1; e_addr = ptr; e_data = smp;
              ptr = (ptr + 1) % 2048;
              remain = remain - 1;
              if (remain == 0) mmode = 4;
            end
          end
          4: begin
            e_done = 1; e_taddr = tptr; mmode = 5;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "mem_we", mem_we, e_we);
      if (e_we != 0) begin
        chk(cur_req, "mem_addr", mem_addr, e_addr);
        chk(cur_req, "mem_wdata", mem_wdata, e_data);
      end
      chk(cur_req, "done", done, e_done);
      chk(cur_req, "trig_addr", trig_addr, e_taddr);
    end
  end

  task automatic cyc(int v, bit sv, bit f, bit s);
    @(negedge clk);
    smp = v[7:0]; vld = sv; frc = f; start = s;
  endtask

  task automatic begin_cap();
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
  endtask

  task automatic finish_post(int n);
    for (int i = 0; i < n; i++) cyc(60 + i, 1, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "mem_addr", mem_addr, 0);
    chk("R1", "mem_wdata", mem_wdata, 0);
    chk("R1", "done", done, 0);
    chk("R1", "trig_addr", trig_addr, 0);
    rst = 1'b0;
    cyc(200, 1, 0, 0);
    cyc(10, 1, 0, 0);
    chk("R1", "mem_we idle", mem_we, 0);

    // R3 rising crossing, equality meets level; R11 gaps ignored
    cur_req = "R3";
    cfg_lvl = 128; cfg_fall = 0; cfg_hold = 4; cfg_post = 5;
    begin_cap();
    for (int i = 0; i < 10; i++) begin
      cyc(50, 1, 0, 0);
      if (i == 4) cyc(200, 0, 0, 0); // R11 invalid high sample
    end
    cyc(128, 1, 0, 0);
    finish_post(5);
    chk("R3", "trig_addr", trig_addr, 10);
    chk("R6", "last mem_addr", mem_addr, 15);
    chk("R7", "done", done, 1);

    // R10 force and samples while done
    cur_req = "R10";
    cyc(200, 1, 1, 0);
    cyc(5, 1, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R10", "done", done, 1);
    chk("R10", "trig_addr", trig_addr, 10);
    chk("R10", "mem_addr", mem_addr, 15);

    // R4 falling crossing
    cur_req = "R4";
    cfg_lvl = 100; cfg_fall = 1; cfg_hold = 3; cfg_post = 2;
    begin_cap();
    chk("R9", "done cleared", done, 0);
    for (int i = 0; i < 6; i++) cyc(200, 1, 0, 0);
    cyc(100, 1, 0, 0);
    finish_post(2);
    chk("R4", "trig_addr", trig_addr, 6);
    chk("R4", "last mem_addr", mem_addr, 8);

    // R5 crossing on the sample that would finish holdoff is blocked
    cur_req = "R5";
    cfg_lvl = 128; cfg_fall = 0; cfg_hold = 5; cfg_post = 1;
    begin_cap();
    cyc(50, 1, 0, 0); cyc(200, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(50, 1, 0, 0);
    cyc(200, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(50, 1, 0, 0);
    cyc(200, 1, 0, 0);
    finish_post(1);
    chk("R5", "trig_addr", trig_addr, 12);

    // R11 invalid clocks do not count toward holdoff
    cur_req = "R11";
    cfg_hold = 3; cfg_post = 1;
    begin_cap();
    cyc(50, 1, 0, 0); cyc(50, 0, 0, 0); cyc(50, 0, 0, 0);
    cyc(200, 1, 0, 0);
    cyc(50, 1, 0, 0); cyc(50, 1, 0, 0); cyc(50, 1, 0, 0);
    cyc(200, 1, 0, 0);
    finish_post(1);
    chk("R11", "trig_addr", trig_addr, 5);

    // R11 first sample cannot trigger; R6 zero post count
    cfg_hold = 0; cfg_post = 0;
    begin_cap();
    cyc(200, 1, 0, 0); cyc(50, 1, 0, 0); cyc(200, 1, 0, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R11", "trig_addr", trig_addr, 2);
    cur_req = "R6";
    cyc(10, 1, 0, 0); cyc(220, 1, 0, 0); cyc(0, 0, 0, 0);
    chk("R6", "mem_addr after stop", mem_addr, 2);
    chk("R6", "done", done, 1);

    // R8 force with a sample, force before a sample, force on a crossing
    cur_req = "R8";
    cfg_hold = 1000; cfg_post = 3;
    begin_cap();
    cyc(50, 1, 0, 0); cyc(50, 1, 0, 0); cyc(50, 1, 1, 0);
    finish_post(3);
    chk("R8", "trig_addr same cycle", trig_addr, 2);
    cfg_post = 1;
    begin_cap();
    cyc(50, 1, 0, 0); cyc(50, 0, 1, 0); cyc(0, 0, 0, 0); cyc(40, 1, 0, 0);
    finish_post(1);
    chk("R8", "trig_addr pending", trig_addr, 1);
    cfg_hold = 0; cfg_post = 2;
    begin_cap();
    cyc(50, 1, 0, 0); cyc(200, 1, 1, 0);
    finish_post(2);
    chk("R8", "trig_addr coincident", trig_addr, 1);
    chk("R8", "last mem_addr", mem_addr, 3);

    // R9 restart mid-capture, and force alongside start ignored
    cur_req = "R9";
    cfg_hold = 1000; cfg_post = 1;
    begin_cap();
    for (int i = 0; i < 5; i++) cyc(50, 1, 0, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(70, 1, 0, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R9", "done after start with force", done, 0);
    chk("R9", "mem_addr restarted", mem_addr, 3);
    cyc(70, 1, 1, 0);
    finish_post(1);
    chk("R9", "trig_addr", trig_addr, 4);

    // R2 circular wrap before trigger
    cur_req = "R2";
    cfg_lvl = 255; cfg_hold = 16'hFFFF; cfg_post = 1;
    begin_cap();
    for (int i = 0; i < 2100; i++) cyc(i % 200, 1, 0, 0);
    cyc(77, 1, 1, 0);
    finish_post(1);
    chk("R2", "trig_addr after wrap", trig_addr, 52);
    chk("R2", "last mem_addr", mem_addr, 53);

    summary();
    $finish;
  end

endmodule